// File: doc/BRIEF.md
# Digital Thermometer SPI Register Slave

This block is the serial register side of a digital temperature sensor. An SPI master raises an active-high chip select, sends one address byte, then exchanges one or more data bytes. Bit 7 of the address byte chooses the direction. The remaining seven bits choose the register. Reads walk downward through the register space, so a single frame that starts at the result high byte returns the whole temperature and then the control byte.

A control byte selects the conversion mode. Shutdown is the reset state. With the shutdown bit cleared, the sensor converts continuously. A one-shot request performs a single conversion and then the sensor falls back to shutdown. The analog front end is replaced by a parallel input that carries the measured 10-bit two's-complement code. A conversion timer copies that code into the result registers at the end of each conversion period. The conversion period is a parameter, so that simulation can use a short interval.

The serial inputs are oversampled by the system clock through a synchronizer whose depth is a parameter. The level of the serial clock at the moment chip select rises picks the clock polarity for the frame.

Top module: `thermo_spi_slave`

## Requirements
- R1: A frame exists only while `csel_hi` is high. Serial clock edges seen while it is low are ignored. Dropping it in the middle of a byte discards that byte, so a partly sent control write leaves the control byte unchanged. `spi_dout` is 0 while `csel_hi` is low and during the address byte.
- R2: The first byte of a frame is the address. If its bit 7 is 1, the frame is a write. If its bit 7 is 0, the frame is a read. Bits 6..0 are the register number. The control register is number 0, so it is written with address 0x80 and read with address 0x00.
- R3: Each read data byte returns the current register and then moves the pointer down by one. Register 2 is the result high byte, register 1 is the result low byte and register 0 is the control byte, so a read from 0x02 returns high, low, control in that order. A register number with no register behind it, including the wrap from 0 to 0x7F, reads 0x00.
- R4: The high byte holds bits 9..2 of the stored 10-bit code. The low byte holds bits 1..0 of the code in its bits 7..6, and its bits 5..0 read 0.
- R5: After reset the control byte reads 0x01 (shutdown), both result bytes read 0x00, and no conversion takes place whatever the sensor code does.
- R6: While control bit 0 is 0, a conversion completes every CONV_CYCLES clocks. Each completion loads the current `sensor_code`, so the result follows the input.
- R7: Completing a control write starts a new conversion period from zero if the written value has bit 0 equal to 0 or bit 4 equal to 1. A write of 0x01 stops conversions and holds the result.
- R8: A control write with bit 4 set and bit 0 set (for example 0x11) gives exactly one conversion, CONV_CYCLES clocks after the write. The result does not change before that point. At completion, control bit 4 clears and the result then stays frozen.
- R9: If `spi_clk` is low when `csel_hi` rises, data is sampled on rising edges and driven on falling edges. If it is high, the edges swap. Bytes move most-significant bit first in both directions.
- R10: Only control bits 4 and 0 are stored. All other control bits read 0. Writes to any register other than 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| csel_hi | input | 1 | Active-high chip select that frames a transfer |
| spi_clk | input | 1 | Serial clock from the master |
| spi_din | input | 1 | Serial data from the master |
| spi_dout | output | 1 | Serial data to the master |
| sensor_code | input | TEMP_W | Measured temperature code, two's complement, 0.25 degree per LSB |

## Verification
The bench builds the block with a conversion period of 400 clocks and the default two-stage synchronizer. At that period, a whole read frame fits inside one conversion interval, so the bench can show that a one-shot result is not yet visible right after the write, and that it is visible one period later. The short period also allows a sweep of 64 sensor codes in continuous mode, including both sign boundaries and both ends of the range. The sweep alternates the clock polarity on every read, and each expected byte is computed by slicing the code.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
   localparam int unsigned REG_CTRL   = 0;
   localparam int unsigned REG_RES_LO = 1;
   localparam int unsigned REG_RES_HI = 2;
   localparam int unsigned CTRL_SHDN_BIT = 0;
   localparam int unsigned CTRL_ONCE_BIT = 4;

   typedef struct packed {
      logic once;
      logic shdn;
   } ctrl_t;
endpackage

// File: rtl/spi_byte_port.sv
module spi_byte_port #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BYTE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csel_i,
   input  logic              sck_i,
   input  logic              sdi_i,
   input  logic [BYTE_W-1:0] tx_byte_i,
   output logic              frame_start_o,
   output logic              byte_valid_o,
   output logic              byte_first_o,
   output logic [BYTE_W-1:0] byte_data_o,
   output logic              sdo_o
);
   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("spi_byte_port: SYNC_STAGES must be at least 1");
   end
   if (BYTE_W != (1 << CNT_W)) begin : g_bad_width
      $error("spi_byte_port: BYTE_W must be a power of two");
   end

   logic [2:0] sync_q [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      end else begin
         sync_q[0] <= {csel_i, sck_i, sdi_i};
         for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      end
   end

   logic ce_s, sck_s, sdi_s;
   assign {ce_s, sck_s, sdi_s} = sync_q[SYNC_STAGES-1];

   logic ce_p, sck_p, cpol_q, first_q, sdo_q;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sr;

   logic ce_rise, in_frame, sck_rise, sck_fall, sample_edge, drive_edge;
   assign ce_rise     = ce_s & ~ce_p;
   assign in_frame    = ce_s & ce_p;
   assign sck_rise    = sck_s & ~sck_p;
   assign sck_fall    = ~sck_s & sck_p;
   assign sample_edge = in_frame & (cpol_q ? sck_fall : sck_rise);
   assign drive_edge  = in_frame & (cpol_q ? sck_rise : sck_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_p    <= 1'b0;
         sck_p   <= 1'b0;
         cpol_q  <= 1'b0;
         first_q <= 1'b0;
         sdo_q   <= 1'b0;
         bit_cnt <= '0;
         rx_sr   <= '0;
      end else begin
         ce_p  <= ce_s;
         sck_p <= sck_s;
         if (!ce_s) begin
            bit_cnt <= '0;
            sdo_q   <= 1'b0;
         end else if (ce_rise) begin
            cpol_q  <= sck_s;
            first_q <= 1'b1;
            bit_cnt <= '0;
            sdo_q   <= 1'b0;
         end else begin
            if (sample_edge) begin
               rx_sr   <= {rx_sr[BYTE_W-3:0], sdi_s};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == LAST_BIT) first_q <= 1'b0;
            end
            if (drive_edge) sdo_q <= tx_byte_i[LAST_BIT - bit_cnt];
         end
      end
   end

   assign frame_start_o = ce_rise;
   assign byte_valid_o  = sample_edge & (bit_cnt == LAST_BIT);
   assign byte_first_o  = first_q;
   assign byte_data_o   = {rx_sr, sdi_s};
   assign sdo_o         = sdo_q;

   // R1: the output is quiet once chip select has been seen low
   assert_sdo_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_p |-> !sdo_q);
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
   parameter int unsigned CONV_CYCLES = 150_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic start_run_i,
   input  logic keep_run_i,
   output logic done_o
);
   localparam int unsigned CNT_W = $clog2(CONV_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

   if (CONV_CYCLES < 2) begin : g_bad_period
      $error("conv_timer: CONV_CYCLES must be at least 2");
   end

   logic             run_q;
   logic [CNT_W-1:0] cnt_q;

   assign done_o = run_q & (cnt_q == LAST) & ~start_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (start_i) begin
         run_q <= start_run_i;
         cnt_q <= '0;
      end else if (run_q) begin
         if (cnt_q == LAST) begin
            cnt_q <= '0;
            run_q <= keep_run_i;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R6: completions are at least a period apart, never back to back
   assert_done_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

// File: rtl/thermo_regs.sv
module thermo_regs
   import thermo_pkg::*;
#(
   parameter int unsigned TEMP_W = 10,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start_i,
   input  logic              byte_valid_i,
   input  logic              byte_first_i,
   input  logic [DATA_W-1:0] byte_data_i,
   input  logic              conv_done_i,
   input  logic [TEMP_W-1:0] sensor_code_i,
   output logic [DATA_W-1:0] tx_byte_o,
   output logic              ctrl_wr_o,
   output ctrl_t             ctrl_o
);
   localparam int unsigned PTR_W   = DATA_W - 1;
   localparam int unsigned LO_BITS = TEMP_W - DATA_W;

   if (TEMP_W <= DATA_W || TEMP_W > 2 * DATA_W) begin : g_bad_temp
      $error("thermo_regs: TEMP_W must lie between DATA_W+1 and 2*DATA_W");
   end

   logic              dir_wr_q;
   logic [PTR_W-1:0]  ptr_q;
   ctrl_t             ctrl_q;
   logic [TEMP_W-1:0] result_q;
   logic [DATA_W-1:0] tx_q;

   function automatic logic [DATA_W-1:0] reg_read(input logic [PTR_W-1:0] idx);
      logic [DATA_W-1:0] v;
      v = '0;
      case (idx)
         PTR_W'(REG_CTRL): begin
            v[CTRL_SHDN_BIT] = ctrl_q.shdn;
            v[CTRL_ONCE_BIT] = ctrl_q.once;
         end
         PTR_W'(REG_RES_LO): v = {result_q[LO_BITS-1:0], {(DATA_W-LO_BITS){1'b0}}};
         PTR_W'(REG_RES_HI): v = result_q[TEMP_W-1:LO_BITS];
         default:            v = '0;
      endcase
      return v;
   endfunction

   assign ctrl_wr_o = byte_valid_i & ~byte_first_i & dir_wr_q & (ptr_q == PTR_W'(REG_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_wr_q <= 1'b0;
         ptr_q    <= '0;
         tx_q     <= '0;
      end else if (frame_start_i) begin
         tx_q <= '0;
      end else if (byte_valid_i) begin
         if (byte_first_i) begin
            dir_wr_q <= byte_data_i[DATA_W-1];
            if (byte_data_i[DATA_W-1]) begin
               ptr_q <= byte_data_i[PTR_W-1:0];
               tx_q  <= '0;
            end else begin
               ptr_q <= byte_data_i[PTR_W-1:0] - 1'b1;
               tx_q  <= reg_read(byte_data_i[PTR_W-1:0]);
            end
         end else begin
            ptr_q <= ptr_q - 1'b1;
            tx_q  <= dir_wr_q ? '0 : reg_read(ptr_q);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '{once: 1'b0, shdn: 1'b1};
         result_q <= '0;
      end else begin
         if (ctrl_wr_o) begin
            ctrl_q.shdn <= byte_data_i[CTRL_SHDN_BIT];
            ctrl_q.once <= byte_data_i[CTRL_ONCE_BIT];
         end else if (conv_done_i) begin
            ctrl_q.once <= 1'b0;
         end
         if (conv_done_i) result_q <= sensor_code_i;
      end
   end

   assign tx_byte_o = tx_q;
   assign ctrl_o    = ctrl_q;

   // R3: every data byte moves the register pointer one step down
   assert_ptr_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_i && !byte_first_i) |=> ptr_q == $past(ptr_q) - 1'b1);
   // R5: the timer never completes while the sensor sits in shutdown
   assert_no_conv_shdn_R5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done_i |-> (!ctrl_q.shdn || ctrl_q.once));
   // R6: a completion captures the code present on that cycle
   assert_result_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done_i |=> result_q == $past(sensor_code_i));
   // R8: a finished single conversion drops back to shutdown
   assert_once_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done_i && !ctrl_wr_o && ctrl_q.once && ctrl_q.shdn) |=> (!ctrl_q.once && ctrl_q.shdn));
endmodule

// File: rtl/thermo_spi_slave.sv
module thermo_spi_slave
   import thermo_pkg::*;
#(
   parameter int unsigned CONV_CYCLES = 150_000,
   parameter int unsigned TEMP_W      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csel_hi,
   input  logic              spi_clk,
   input  logic              spi_din,
   output logic              spi_dout,
   input  logic [TEMP_W-1:0] sensor_code
);
   localparam int unsigned DATA_W = 8;

   logic              frame_start, byte_valid, byte_first, ctrl_wr, conv_done;
   logic [DATA_W-1:0] byte_data, tx_byte;
   ctrl_t             ctrl;

   spi_byte_port #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(DATA_W)) u_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .csel_i        (csel_hi),
      .sck_i         (spi_clk),
      .sdi_i         (spi_din),
      .tx_byte_i     (tx_byte),
      .frame_start_o (frame_start),
      .byte_valid_o  (byte_valid),
      .byte_first_o  (byte_first),
      .byte_data_o   (byte_data),
      .sdo_o         (spi_dout)
   );

   thermo_regs #(.TEMP_W(TEMP_W), .DATA_W(DATA_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start),
      .byte_valid_i  (byte_valid),
      .byte_first_i  (byte_first),
      .byte_data_i   (byte_data),
      .conv_done_i   (conv_done),
      .sensor_code_i (sensor_code),
      .tx_byte_o     (tx_byte),
      .ctrl_wr_o     (ctrl_wr),
      .ctrl_o        (ctrl)
   );

   conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (ctrl_wr),
      .start_run_i (~byte_data[CTRL_SHDN_BIT] | byte_data[CTRL_ONCE_BIT]),
      .keep_run_i  (~ctrl.shdn),
      .done_o      (conv_done)
   );
endmodule

// File: tb/thermo_spi_slave_test.sv
module thermo_spi_slave_test;
   localparam int CONV = 400;
   localparam int HALF = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csel = 1'b0, sclk = 1'b0, sdi = 1'b0;
   logic sdo;
   logic [9:0] code = '0;
   logic [31:0] m_tx, m_rx;
   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   thermo_spi_slave #(.CONV_CYCLES(CONV), .TEMP_W(10), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .csel_hi(csel), .spi_clk(sclk),
      .spi_din(sdi), .spi_dout(sdo), .sensor_code(code));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input logic cpol, input int nbits);
      @(negedge clk);
      sclk = cpol;
      idle(4);
      csel = 1'b1;
      idle(4);
      m_rx = '0;
      for (int b = 0; b < nbits; b++) begin
         sdi = m_tx[31-b];
         idle(HALF);
         m_rx[31-b] = sdo;
         sclk = ~cpol;
         idle(HALF);
         sclk = cpol;
      end
      idle(HALF);
      csel = 1'b0;
      idle(6);
   endtask

   task automatic wr_ctrl(input logic cpol, input logic [7:0] val);
      m_tx = {8'h80, val, 16'h0};
      frame(cpol, 16);
   endtask

   task automatic rd(input logic cpol, input logic [7:0] addr, input int nbytes);
      m_tx = {addr, 24'h0};
      frame(cpol, 8 + 8 * nbytes);
   endtask

   initial begin
      logic [9:0] last;
      idle(3);
      rst_n = 1'b1;
      idle(3);
      check("R1 reset dout", {7'd0, sdo}, 8'h00);

      // R5 reset state, R3 downward burst from 0x02
      rd(1'b0, 8'h02, 3);
      check("R5 hi after reset", m_rx[23:16], 8'h00);
      check("R5 lo after reset", m_rx[15:8], 8'h00);
      check("R3 burst ends at ctrl", m_rx[7:0], 8'h01);
      check("R1 dout during address", m_rx[31:24], 8'h00);
      // R9 opposite polarity, R2 read of reg 0
      rd(1'b1, 8'h00, 1);
      check("R9 R2 ctrl read idle-high", m_rx[23:16], 8'h01);
      rd(1'b0, 8'h05, 1);
      check("R3 unmapped reads zero", m_rx[23:16], 8'h00);
      rd(1'b1, 8'h01, 2);
      check("R3 lo then ctrl", m_rx[15:8], 8'h01);
      rd(1'b0, 8'h00, 2);
      check("R3 wrap below zero", m_rx[15:8], 8'h00);

      // R5 no conversion in shutdown
      code = 10'h2C5;
      idle(2 * CONV);
      rd(1'b0, 8'h02, 1);
      check("R5 shutdown holds result", m_rx[23:16], 8'h00);

      // R10 writes elsewhere ignored
      m_tx = {8'h82, 8'hAA, 8'h55, 8'h0};
      frame(1'b0, 24);
      rd(1'b0, 8'h02, 3);
      check("R10 hi not writable", m_rx[23:16], 8'h00);
      check("R10 lo not writable", m_rx[15:8], 8'h00);
      check("R10 ctrl untouched", m_rx[7:0], 8'h01);

      // R1 aborted control write and clocks outside a frame
      m_tx = {8'h80, 8'h11, 16'h0};
      frame(1'b0, 12);
      sdi = 1'b1;
      for (int k = 0; k < 20; k++) begin
         idle(HALF);
         sclk = ~sclk;
      end
      sclk = 1'b0;
      idle(2 * CONV);
      rd(1'b0, 8'h02, 3);
      check("R1 aborted write no conversion", m_rx[23:16], 8'h00);
      check("R1 aborted write ctrl", m_rx[7:0], 8'h01);

      // R8 / R7 one-shot
      wr_ctrl(1'b1, 8'h11);
      rd(1'b0, 8'h02, 2);
      check("R8 result not early hi", m_rx[23:16], 8'h00);
      check("R8 result not early lo", m_rx[15:8], 8'h00);
      idle(CONV);
      rd(1'b0, 8'h02, 3);
      check("R4 R7 one-shot hi", m_rx[23:16], 8'hB1);
      check("R4 one-shot lo", m_rx[15:8], 8'h40);
      check("R8 back to shutdown", m_rx[7:0], 8'h01);
      code = 10'h155;
      idle(2 * CONV);
      rd(1'b1, 8'h02, 2);
      check("R8 result frozen hi", m_rx[23:16], 8'hB1);
      check("R8 result frozen lo", m_rx[15:8], 8'h40);

      // R10 only bits 4 and 0 stored
      wr_ctrl(1'b0, 8'hFF);
      rd(1'b0, 8'h00, 1);
      check("R10 stored bits", m_rx[23:16], 8'h11);
      idle(CONV);
      rd(1'b0, 8'h02, 3);
      check("R8 second one-shot hi", m_rx[23:16], 8'h55);
      check("R4 second one-shot lo", m_rx[15:8], 8'h40);
      check("R8 ctrl after second", m_rx[7:0], 8'h01);

      // R6 continuous sweep
      wr_ctrl(1'b0, 8'h00);
      for (int i = 0; i < 64; i++) begin
         logic [9:0] c;
         case (i)
            0: c = 10'h000;
            1: c = 10'h3FF;
            2: c = 10'h200;
            3: c = 10'h1FF;
            default: c = 10'((i * 97 + 5) % 1024);
         endcase
         code = c;
         idle(CONV + 20);
         rd(1'(i), 8'h02, 3);
         check("R6 R4 sweep hi", m_rx[23:16], c[9:2]);
         check("R6 R4 sweep lo", m_rx[15:8], {c[1:0], 6'b0});
         check("R6 sweep ctrl", m_rx[7:0], 8'h00);
      end

      // R7 write 0x01 stops conversions
      last = code;
      wr_ctrl(1'b0, 8'h01);
      code = ~last;
      idle(2 * CONV);
      rd(1'b0, 8'h02, 2);
      check("R7 stop holds hi", m_rx[23:16], last[9:2]);
      check("R7 stop holds lo", m_rx[15:8], {last[1:0], 6'b0});

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule